// File: doc/BRIEF.md
# Halt and Wake-up Controller

This block sequences the low-power states of a small 4-bit controller core. On a software command it parks the core in one of two standby modes. In halt, only the core clock is stopped; the oscillator-driven divider chain and the LCD scan logic keep running so that timekeeping and display carry on. In hold, the divider and LCD domains are stopped as well, and the whole part rests until an external pin activity arrives.

Four wake sources are watched, and each has its own enable bit:
- a change on any selected line of the input port;
- a change on the interrupt pin;
- an overflow pulse from the clock divider;
- an underflow pulse from the programmable timer.

The two pin sources pass through two-flop synchronizers. Each one is compared against a snapshot that follows the pin while the core runs and freezes when standby begins. Every enabled source that fires is recorded in a sticky 4-bit cause register, which software clears with a strobe.

The controller is a three-state machine. The states are:
- `ST_RUN`: core clocked.
- `ST_HALT`: core gated; divider and LCD still enabled.
- `ST_HOLD`: everything gated.

The transitions are:
- RUN->HALT on `halt_req`.
- RUN->HOLD on `hold_req`.
- HALT->RUN on any enabled event.
- HOLD->RUN on an enabled port or interrupt-pin event.
- RUN->RUN (refused entry) when an allowed event is already present in the request cycle.

Top module: `standby_ctrl`

## Requirements
- R1: After reset the block is in RUN: `core_clk_en`, `div_en` and `lcd_en` are 1 and `cause` is 0.
- R2: A `halt_req` in RUN, with no enabled event present in that cycle and no `hold_req`, drives `core_clk_en` to 0 on the next edge, while `div_en` and `lcd_en` stay 1.
- R3: A `hold_req` in RUN, with no enabled pin event present, drives all three enables to 0 on the next edge. When both requests arrive together, hold wins.
- R4: Port wake: `port_in` is synchronized by two flops. In standby, a line whose `port_mask` bit is 1, with `wake_en[0]`=1, that differs from its value at standby entry restarts the core. `core_clk_en` returns on the third edge after the pin change, and `cause[0]` is set.
- R5: Interrupt-pin wake: with `wake_en[1]`=1, a change of `int_in` during standby restarts the core on the third edge after the change and sets `cause[1]`.
- R6: In halt, a `div_ovf` pulse with `wake_en[2]`=1 restarts the core on the next edge and sets `cause[2]`. A `tmr_unf` pulse with `wake_en[3]`=1 does the same and sets `cause[3]`.
- R7: In hold, `div_ovf` and `tmr_unf` have no effect: the enables stay 0 and `cause` does not change.
- R8: A source whose `wake_en` bit is 0, or a port line whose `port_mask` bit is 0, neither wakes the block nor sets `cause`.
- R9: If an allowed enabled event is present in the cycle of a standby request, the block stays in RUN and latches that event's cause bit. For halt, all four sources are allowed; for hold, only the pin sources are.
- R10: `cause` bits are sticky and accumulate when several sources fire. `cause_clr` clears them on the next edge, and a bit that fires in the same cycle as the clear stays set.
- R11: Standby requests arriving while already in halt or hold are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Divider-domain clock, always running |
| rst_n | input | 1 | Active-low asynchronous reset |
| halt_req | input | 1 | Enter halt (one-cycle strobe) |
| hold_req | input | 1 | Enter hold (one-cycle strobe) |
| wake_en | input | 4 | Source enables: [0] port, [1] interrupt pin, [2] divider overflow, [3] timer underflow |
| port_mask | input | PORT_W | Per-line selection of port lines that may wake |
| port_in | input | PORT_W | Asynchronous port pins |
| int_in | input | 1 | Asynchronous interrupt pin |
| div_ovf | input | 1 | Divider overflow pulse |
| tmr_unf | input | 1 | Timer underflow pulse |
| cause_clr | input | 1 | Clear strobe for the cause register |
| core_clk_en | output | 1 | Core clock enable |
| div_en | output | 1 | Divider domain enable |
| lcd_en | output | 1 | LCD scan domain enable |
| cause | output | 4 | Sticky wake cause, bit order as `wake_en` |

## Verification
The bench builds the block with `PORT_W` = 4. With only four port lines, random toggles, masks and enables often fall on the same few bits, so masked-line, disabled-source and multi-source cases occur frequently. The directed part covers the three-edge pin latency, refused entry, hold ignoring internal pulses, and set-over-clear in the cause register.

// File: rtl/standby_pkg.sv
package standby_pkg;
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HALT = 2'd1,
        ST_HOLD = 2'd2
    } stby_state_e;

    localparam int SRC_N    = 4;
    localparam int SRC_PORT = 0;
    localparam int SRC_INT  = 1;
    localparam int SRC_DIV  = 2;
    localparam int SRC_TMR  = 3;

    // sources allowed to end a hold
    localparam logic [SRC_N-1:0] EXT_MASK = (1 << SRC_PORT) | (1 << SRC_INT);
endpackage

// File: rtl/sb_sync2.sv
module sb_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/sb_wake_detect.sv
module sb_wake_detect
    import standby_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              track,      // snapshot follows inputs while high
    input  logic [PORT_W-1:0] port_s,
    input  logic              int_s,
    input  logic [PORT_W-1:0] port_mask,
    input  logic [SRC_N-1:0]  wake_en,
    input  logic              div_ovf,
    input  logic              tmr_unf,
    output logic [SRC_N-1:0]  evt
);
    logic [PORT_W-1:0] port_snap;
    logic              int_snap;
    logic [PORT_W-1:0] port_diff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            port_snap <= '0;
            int_snap  <= 1'b0;
        end else if (track) begin
            port_snap <= port_s;
            int_snap  <= int_s;
        end
    end

    assign port_diff = (port_s ^ port_snap) & port_mask;

    always_comb begin
        evt           = '0;
        evt[SRC_PORT] = wake_en[SRC_PORT] & (|port_diff);
        evt[SRC_INT]  = wake_en[SRC_INT]  & (int_s ^ int_snap);
        evt[SRC_DIV]  = wake_en[SRC_DIV]  & div_ovf;
        evt[SRC_TMR]  = wake_en[SRC_TMR]  & tmr_unf;
    end
endmodule

// File: rtl/sb_cause_reg.sv
module sb_cause_reg #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         clr,
    output logic [N-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= (clr ? '0 : q) | set;
    end
endmodule

// File: rtl/standby_ctrl.sv
module standby_ctrl
    import standby_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt_req,
    input  logic              hold_req,
    input  logic [3:0]        wake_en,
    input  logic [PORT_W-1:0] port_mask,
    input  logic [PORT_W-1:0] port_in,
    input  logic              int_in,
    input  logic              div_ovf,
    input  logic              tmr_unf,
    input  logic              cause_clr,
    output logic              core_clk_en,
    output logic              div_en,
    output logic              lcd_en,
    output logic [3:0]        cause
);
    stby_state_e      state_q, state_d;
    logic [PORT_W-1:0] port_s;
    logic             int_s;
    logic [SRC_N-1:0] evt_vec;
    logic [SRC_N-1:0] evt_ext;
    logic [SRC_N-1:0] fire;

    sb_sync2 #(.W(PORT_W + 1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({int_in, port_in}),
        .q    ({int_s, port_s})
    );

    sb_wake_detect #(.PORT_W(PORT_W)) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .track    (state_q == ST_RUN),
        .port_s   (port_s),
        .int_s    (int_s),
        .port_mask(port_mask),
        .wake_en  (wake_en),
        .div_ovf  (div_ovf),
        .tmr_unf  (tmr_unf),
        .evt      (evt_vec)
    );

    assign evt_ext = evt_vec & EXT_MASK;

    // next state and the events that count in this state
    always_comb begin
        state_d = state_q;
        fire    = '0;
        unique case (state_q)
            ST_RUN: begin
                if (hold_req) begin
                    fire    = evt_ext;
                    state_d = (|evt_ext) ? ST_RUN : ST_HOLD;
                end else if (halt_req) begin
                    fire    = evt_vec;
                    state_d = (|evt_vec) ? ST_RUN : ST_HALT;
                end
            end
            ST_HALT: begin
                fire = evt_vec;
                if (|evt_vec) state_d = ST_RUN;
            end
            ST_HOLD: begin
                fire = evt_ext;
                if (|evt_ext) state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        core_clk_en = (state_q == ST_RUN);
        div_en      = (state_q != ST_HOLD);
        lcd_en      = (state_q != ST_HOLD);
    end

    sb_cause_reg #(.N(SRC_N)) u_cause (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (fire),
        .clr  (cause_clr),
        .q    (cause)
    );
endmodule

// File: rtl/standby_ctrl_chk.sv
module standby_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       halt_req,
    input logic       hold_req,
    input logic       cause_clr,
    input logic       core_clk_en,
    input logic       div_en,
    input logic       lcd_en,
    input logic [3:0] cause,
    input logic [3:0] evt
);
    // R2: a running core implies both timekeeping domains run
    a_r2_run_domains: assert property (@(posedge clk) disable iff (!rst_n)
        core_clk_en |-> (div_en && lcd_en));

    // R3: divider and LCD enables move together; hold stops the core too
    a_r3_hold_all_off: assert property (@(posedge clk) disable iff (!rst_n)
        !div_en |-> (!lcd_en && !core_clk_en));

    // R2: clean halt request gates only the core
    a_r2_halt_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (core_clk_en && halt_req && !hold_req && evt == 4'b0000)
            |=> (!core_clk_en && div_en));

    // R6: any enabled event in halt restarts the core next edge
    a_r6_halt_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_clk_en && div_en && (|evt)) |=> core_clk_en);

    // R7: hold persists without a pin event
    a_r7_hold_internal_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!div_en && evt[1:0] == 2'b00) |=> !div_en);

    // R11: requests while halted do not reach hold
    a_r11_no_hold_from_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_clk_en && div_en) |=> div_en);

    // R10: cause bits only fall on a clear
    a_r10_cause_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !cause_clr |=> ((cause & $past(cause)) == $past(cause)));
endmodule

bind standby_ctrl standby_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .halt_req   (halt_req),
    .hold_req   (hold_req),
    .cause_clr  (cause_clr),
    .core_clk_en(core_clk_en),
    .div_en     (div_en),
    .lcd_en     (lcd_en),
    .cause      (cause),
    .evt        (evt_vec)
);

// File: tb/standby_ctrl_test.sv
module standby_ctrl_test;
    localparam int PW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          halt_req = 0, hold_req = 0, int_in = 0;
    logic          div_ovf = 0, tmr_unf = 0, cause_clr = 0;
    logic [3:0]    wake_en = 4'hF;
    logic [PW-1:0] port_mask = '1, port_in = '0;
    logic          core_clk_en, div_en, lcd_en;
    logic [3:0]    cause;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    // reference state: 0 run, 1 halt, 2 hold
    int            m_state = 0;
    logic [PW-1:0] m_p1 = '0, m_p2 = '0, m_sp = '0;
    logic          m_i1 = 0, m_i2 = 0, m_si = 0;
    logic [3:0]    m_cause = '0;

    standby_ctrl #(.PORT_W(PW)) uut (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .hold_req(hold_req),
        .wake_en(wake_en), .port_mask(port_mask), .port_in(port_in),
        .int_in(int_in), .div_ovf(div_ovf), .tmr_unf(tmr_unf),
        .cause_clr(cause_clr), .core_clk_en(core_clk_en), .div_en(div_en),
        .lcd_en(lcd_en), .cause(cause)
    );

    always #5 clk = ~clk;

    function automatic logic [3:0] calc_evt();
        logic [3:0] e;
        e[0] = wake_en[0] & (|((m_p2 ^ m_sp) & port_mask));
        e[1] = wake_en[1] & (m_i2 ^ m_si);
        e[2] = wake_en[2] & div_ovf;
        e[3] = wake_en[3] & tmr_unf;
        return e;
    endfunction

    task automatic model_edge();
        logic [3:0] e, ext, f;
        int nxt;
        e = calc_evt();
        ext = e & 4'b0011;
        f = '0;
        nxt = m_state;
        if (m_state == 0) begin
            if (hold_req) begin f = ext; nxt = (|ext) ? 0 : 2; end
            else if (halt_req) begin f = e; nxt = (|e) ? 0 : 1; end
            m_sp = m_p2; m_si = m_i2;
        end else if (m_state == 1) begin
            f = e; if (|e) nxt = 0;
        end else begin
            f = ext; if (|ext) nxt = 0;
        end
        m_cause = (cause_clr ? 4'b0 : m_cause) | f;
        m_p2 = m_p1; m_p1 = port_in;
        m_i2 = m_i1; m_i1 = int_in;
        m_state = nxt;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare_model();
        chk("R2 core_clk_en vs model", int'(core_clk_en), int'(m_state == 0));
        chk("R3 div_en vs model", int'(div_en), int'(m_state != 2));
        chk("R3 lcd_en vs model", int'(lcd_en), int'(m_state != 2));
        chk("R10 cause vs model", int'(cause), int'(m_cause));
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_model();
    endtask

    task automatic pulse_div();
        div_ovf = 1; tick(); div_ovf = 0;
    endtask

    task automatic pulse_tmr();
        tmr_unf = 1; tick(); tmr_unf = 0;
    endtask

    task automatic clear_cause();
        cause_clr = 1; tick(); cause_clr = 0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R1 core_clk_en at reset", core_clk_en, 1);
        chk("R1 div_en at reset", div_en, 1);
        chk("R1 lcd_en at reset", lcd_en, 1);
        chk("R1 cause at reset", cause, 0);
        rst_n = 1;
        tick();

        // R2 halt entry, R6 divider wake
        halt_req = 1; tick(); halt_req = 0;
        chk("R2 core gated in halt", core_clk_en, 0);
        chk("R2 divider runs in halt", div_en, 1);
        pulse_div();
        chk("R6 divider wake", core_clk_en, 1);
        chk("R6 divider cause", cause, 4'b0100);
        clear_cause();
        chk("R10 clear", cause, 0);

        // R3 hold, R7 internal ignored, R4 port wake latency
        hold_req = 1; halt_req = 1; tick(); hold_req = 0; halt_req = 0;
        chk("R3 hold wins", div_en, 0);
        pulse_div();
        pulse_tmr();
        chk("R7 hold kept", div_en, 0);
        chk("R7 cause untouched", cause, 0);
        port_in[0] = 1; tick(); tick();
        chk("R4 not yet awake", core_clk_en, 0);
        tick();
        chk("R4 port wake third edge", core_clk_en, 1);
        chk("R4 port cause", cause, 4'b0001);
        clear_cause();

        // R8 disabled source and masked line
        wake_en = 4'b1110;
        halt_req = 1; tick(); halt_req = 0;
        port_in[1] = 1; repeat (4) tick();
        chk("R8 disabled port ignored", core_clk_en, 0);
        wake_en = 4'b1111; port_mask = 4'b1100;
        repeat (2) tick();
        chk("R8 masked line ignored", core_clk_en, 0);
        chk("R8 no cause", cause, 0);

        // R11 requests while halted
        hold_req = 1; tick(); hold_req = 0;
        chk("R11 hold ignored in halt", div_en, 1);

        // R5 interrupt pin wake
        int_in = 1; repeat (3) tick();
        chk("R5 int wake", core_clk_en, 1);
        chk("R5 int cause", cause, 4'b0010);
        port_mask = '1;
        tick(); tick();
        clear_cause();

        // R9 refused entry
        halt_req = 1; tmr_unf = 1; tick(); halt_req = 0; tmr_unf = 0;
        chk("R9 stays running", core_clk_en, 1);
        chk("R9 cause at request", cause, 4'b1000);
        clear_cause();
        hold_req = 1; div_ovf = 1; tick(); hold_req = 0; div_ovf = 0;
        chk("R9 hold ignores divider at request", div_en, 0);
        port_in[3] = 1; repeat (3) tick();
        chk("R4 hold port wake", core_clk_en, 1);
        clear_cause();

        // R10 accumulate and set over clear
        halt_req = 1; tick(); halt_req = 0;
        div_ovf = 1; tmr_unf = 1; cause_clr = 1; tick();
        div_ovf = 0; tmr_unf = 0; cause_clr = 0;
        chk("R10 set wins, both latched", cause, 4'b1100);
        chk("R6 woke", core_clk_en, 1);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            halt_req  = ($urandom_range(0, 99) < 6);
            hold_req  = ($urandom_range(0, 99) < 3);
            div_ovf   = ($urandom_range(0, 99) < 4);
            tmr_unf   = ($urandom_range(0, 99) < 3);
            cause_clr = ($urandom_range(0, 99) < 5);
            if ($urandom_range(0, 99) < 4) port_in[$urandom_range(0, PW-1)] ^= 1'b1;
            if ($urandom_range(0, 99) < 3) int_in = ~int_in;
            if ($urandom_range(0, 99) < 2) wake_en = 4'($urandom);
            if ($urandom_range(0, 99) < 2) port_mask = PW'($urandom);
            tick();
        end

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule